// File: doc/BRIEF.md
# Shrinking Generator Bit Source

This block produces a pseudorandom bit stream by irregular decimation. Two linear feedback shift registers step together. The shorter one, the selector, decides whether the current output bit of the longer one, the data register, is emitted or dropped. Kept bits come out one at a time with a valid strobe. Each kept bit also enters a holding register as wide as the data register. A counter of kept bits ends the burst with a one-cycle done pulse.

A run starts with an init request. The selector is loaded with its own feedback tap mask. The data register is loaded with a caller-supplied challenge seed. While enable is high, each cycle advances both registers. A run yields BURST kept bits (600 by default). The first BURST-MASK_BITS of them (480) are flagged as configuration-select bits for downstream oscillator chains. The last MASK_BITS of them (120) are flagged as mask bits, to be held aside and combined later with a voted response.

Top module: `shrink_bitgen`

## Requirements
- R1: After reset, bit_vld_o, done_o, mask_phase_o and bit_o are 0, kept_cnt_o is 0 and hold_o is all zeros. No bit is produced before the first init.
- R2: On init_i, the selector is loaded with SEL_TAPS and the data register is loaded with seed_i. A seed of all zeros is replaced by the value 1, so the data register never locks at zero.
- R3: Both registers use the Fibonacci form. On a step, the state S of width W becomes {S[W-2:0], ^(S & TAPS)}, and the bit a register presents on that step is S[W-1] taken before the update. Bit i of TAPS selects stage i.
- R4: A step happens in each cycle in which en_i is 1, init_i is 0 and a run is active. When the selector bit is 1, the data bit is kept: in the next cycle bit_vld_o is 1 for one cycle and bit_o equals that data bit. When the selector bit is 0, the data bit is discarded and bit_vld_o stays 0. Both registers advance either way.
- R5: Each kept bit shifts into hold_o at bit 0, and the older bits move one position towards the MSB. init_i clears hold_o.
- R6: kept_cnt_o counts kept bits only, not cycles. It is cleared by init_i and never exceeds BURST.
- R7: mask_phase_o, updated with each kept bit, is 1 when that bit's zero-based index within the run is BURST-MASK_BITS or more, and 0 otherwise.
- R8: done_o is a one-cycle pulse in the same cycle as the valid strobe of the BURST-th kept bit. After it, no step occurs and en_i has no effect on any output until the next init_i.
- R9: While en_i is 0 and init_i is 0, the outputs hold their values and bit_vld_o stays 0. The next enabled step continues the sequence where it stopped.
- R10: init_i takes priority over en_i and restarts a run even in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Load both registers and start a run |
| en_i | input | 1 | Advance both registers this cycle |
| seed_i | input | DAT_W | Challenge seed for the data register |
| bit_o | output | 1 | Most recent kept bit |
| bit_vld_o | output | 1 | One-cycle strobe for a new kept bit |
| mask_phase_o | output | 1 | Kept bit belongs to the mask part of the burst |
| hold_o | output | DAT_W | Holding register of recent kept bits |
| kept_cnt_o | output | $clog2(BURST+1) | Kept bits so far in this run |
| done_o | output | 1 | One-cycle pulse when the burst completes |

## Verification
The bench builds the block with a 4-bit selector (taps x^4+x^3+1), an 8-bit data register (taps x^8+x^6+x^5+x^4+1), BURST of 40 and MASK_BITS of 8. With these values the selector wraps every 15 steps and the data register every 255 steps. A full burst, the crossing into the mask phase, the end-of-burst pulse and the zero-seed fallback are therefore each reached many times within a few hundred cycles. The narrow holding register is refilled several times per run, so its shift order is checked against a bench model over whole bursts.

// File: rtl/sg_pkg.sv
package sg_pkg;
  typedef enum logic [0:0] {
    SG_IDLE = 1'b0,
    SG_RUN  = 1'b1
  } sg_run_e;
endpackage

// File: rtl/sg_lfsr.sv
module sg_lfsr #(
  parameter int          W        = 8,
  parameter logic [W-1:0] TAPS    = 8'hB8,
  parameter logic [W-1:0] FALLBACK = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  output logic         msb_o
);
  logic [W-1:0] state_q, state_d;
  logic [W-1:0] tapped;
  logic         fb;

  for (genvar i = 0; i < W; i++) begin : g_tap
    assign tapped[i] = TAPS[i] & state_q[i];
  end
  assign fb = ^tapped;

  always_comb begin
    state_d = state_q;
    if (load_i)      state_d = (load_val_i == '0) ? FALLBACK : load_val_i;
    else if (step_i) state_d = {state_q[W-2:0], fb};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= FALLBACK;
    else         state_q <= state_d;
  end

  assign msb_o = state_q[W-1];

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0); // R2
  AST_LFSR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !step_i |=> $stable(state_q)); // R9
endmodule

// File: rtl/sg_collect.sv
module sg_collect
  import sg_pkg::*;
#(
  parameter int DAT_W     = 31,
  parameter int BURST     = 600,
  parameter int MASK_BITS = 120,
  localparam int CNT_W    = $clog2(BURST + 1),
  localparam int SEL_BITS = BURST - MASK_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             step_i,
  input  logic             sel_bit_i,
  input  logic             dat_bit_i,
  output logic             running_o,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             mask_phase_o,
  output logic [DAT_W-1:0] hold_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  sg_run_e          run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DAT_W-1:0] hold_q;
  logic             bit_q, vld_q, mask_q, done_q;
  logic             keep;

  assign keep = step_i & sel_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= SG_IDLE;
      cnt_q  <= '0;
      hold_q <= '0;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
      mask_q <= 1'b0;
      done_q <= 1'b0;
    end else if (init_i) begin
      run_q  <= SG_RUN;
      cnt_q  <= '0;
      hold_q <= '0;
      bit_q  <= 1'b0;
      vld_q  <= 1'b0;
      mask_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      vld_q  <= 1'b0;
      done_q <= 1'b0;
      if (keep) begin
        bit_q  <= dat_bit_i;
        vld_q  <= 1'b1;
        hold_q <= {hold_q[DAT_W-2:0], dat_bit_i};
        cnt_q  <= cnt_q + 1'b1;
        mask_q <= (cnt_q >= CNT_W'(SEL_BITS));
        if (cnt_q == CNT_W'(BURST - 1)) begin
          done_q <= 1'b1;
          run_q  <= SG_IDLE;
        end
      end
    end
  end

  assign running_o    = (run_q == SG_RUN);
  assign bit_o        = bit_q;
  assign bit_vld_o    = vld_q;
  assign mask_phase_o = mask_q;
  assign hold_o       = hold_q;
  assign cnt_o        = cnt_q;
  assign done_o       = done_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(BURST)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8
  AST_DONE_AT_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cnt_q == CNT_W'(BURST)) && vld_q); // R8
  AST_IDLE_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == SG_IDLE) && !init_i |=> !vld_q); // R8
  AST_MASK_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && mask_q |-> cnt_q > CNT_W'(SEL_BITS)); // R7
endmodule

// File: rtl/shrink_bitgen.sv
module shrink_bitgen #(
  parameter int               SEL_W     = 7,
  parameter int               DAT_W     = 31,
  parameter logic [SEL_W-1:0] SEL_TAPS  = 7'h60,
  parameter logic [DAT_W-1:0] DAT_TAPS  = 31'h4800_0000,
  parameter int               BURST     = 600,
  parameter int               MASK_BITS = 120,
  localparam int              CNT_W     = $clog2(BURST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic [DAT_W-1:0] seed_i,
  output logic             bit_o,
  output logic             bit_vld_o,
  output logic             mask_phase_o,
  output logic [DAT_W-1:0] hold_o,
  output logic [CNT_W-1:0] kept_cnt_o,
  output logic             done_o
);
  logic running, step, sel_bit, dat_bit;

  assign step = en_i & running & ~init_i;

  sg_lfsr #(.W(SEL_W), .TAPS(SEL_TAPS), .FALLBACK(SEL_W'(1))) u_sel (
    .clk_i, .rst_ni,
    .load_i(init_i), .load_val_i(SEL_TAPS), .step_i(step), .msb_o(sel_bit)
  );

  sg_lfsr #(.W(DAT_W), .TAPS(DAT_TAPS), .FALLBACK(DAT_W'(1))) u_dat (
    .clk_i, .rst_ni,
    .load_i(init_i), .load_val_i(seed_i), .step_i(step), .msb_o(dat_bit)
  );

  sg_collect #(.DAT_W(DAT_W), .BURST(BURST), .MASK_BITS(MASK_BITS)) u_col (
    .clk_i, .rst_ni,
    .init_i, .step_i(step), .sel_bit_i(sel_bit), .dat_bit_i(dat_bit),
    .running_o(running), .bit_o, .bit_vld_o, .mask_phase_o,
    .hold_o, .cnt_o(kept_cnt_o), .done_o
  );

  AST_VLD_NEEDS_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_vld_o |-> $past(step && sel_bit)); // R4
  AST_DROP_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step && !sel_bit |=> !bit_vld_o); // R4
  AST_EN_LOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !init_i |=> $stable(hold_o) && $stable(kept_cnt_o) && !bit_vld_o); // R9
  AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> kept_cnt_o == '0 && hold_o == '0); // R10
endmodule

// File: tb/shrink_bitgen_bench.sv
module shrink_bitgen_bench;
  localparam int          SW = 4;
  localparam int          DW = 8;
  localparam logic [SW-1:0] ST = 4'hC;
  localparam logic [DW-1:0] DT = 8'hB8;
  localparam int          BURST = 40;
  localparam int          MB    = 8;
  localparam int          SELB  = BURST - MB;
  localparam int          CW    = $clog2(BURST + 1);

  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0, en = 1'b0;
  logic [DW-1:0] seed = '0;
  logic bit_o, vld, mask, done;
  logic [DW-1:0] hold;
  logic [CW-1:0] cnt;

  int total = 0, fails = 0;

  // model state
  logic [SW-1:0] m_sel = '0;
  logic [DW-1:0] m_dat = '0;
  logic [DW-1:0] m_hold = '0;
  int            m_cnt = 0;
  logic m_run = 0, m_bit = 0, m_vld = 0, m_mask = 0, m_done = 0;

  always #5 clk = ~clk;

  shrink_bitgen #(.SEL_W(SW), .DAT_W(DW), .SEL_TAPS(ST), .DAT_TAPS(DT),
                  .BURST(BURST), .MASK_BITS(MB)) u_shrink_bitgen (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .en_i(en), .seed_i(seed),
    .bit_o(bit_o), .bit_vld_o(vld), .mask_phase_o(mask), .hold_o(hold),
    .kept_cnt_o(cnt), .done_o(done)
  );

  function automatic logic [SW-1:0] sel_next(logic [SW-1:0] s);
    return {s[SW-2:0], ^(s & ST)};
  endfunction
  function automatic logic [DW-1:0] dat_next(logic [DW-1:0] s);
    return {s[DW-2:0], ^(s & DT)};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic ini, input logic e, input logic [DW-1:0] sd);
    logic kb, db;
    @(negedge clk);
    init = ini; en = e; seed = sd;
    m_vld = 0; m_done = 0;
    if (ini) begin
      m_sel = ST; m_dat = (sd == '0) ? DW'(1) : sd;
      m_hold = '0; m_cnt = 0; m_run = 1; m_bit = 0; m_mask = 0;
    end else if (e && m_run) begin
      kb = m_sel[SW-1]; db = m_dat[DW-1];
      m_sel = sel_next(m_sel); m_dat = dat_next(m_dat);
      if (kb) begin
        m_vld = 1; m_bit = db; m_mask = (m_cnt >= SELB);
        m_hold = {m_hold[DW-2:0], db};
        m_cnt++;
        if (m_cnt == BURST) begin m_done = 1; m_run = 0; end
      end
    end
    @(posedge clk); #1;
    chk(vld == m_vld, "R4 vld", vld, m_vld);
    chk(bit_o == m_bit, "R3 R4 bit", bit_o, m_bit);
    chk(hold == m_hold, "R5 hold", hold, m_hold);
    chk(int'(cnt) == m_cnt, "R6 count", cnt, m_cnt);
    chk(mask == m_mask, "R7 mask phase", mask, m_mask);
    chk(done == m_done, "R8 done", done, m_done);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [DW-1:0] hsnap;
    int bursts;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(vld == 0 && done == 0 && mask == 0 && bit_o == 0, "R1 flags", {vld, done, mask, bit_o}, 0);
    chk(cnt == 0 && hold == 0, "R1 cnt/hold", int'(cnt) + int'(hold), 0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b1, 8'hFF);
    chk(cnt == 0 && vld == 0, "R1 no output before init", cnt, 0);

    for (int r = 0; r < 8; r++) begin
      logic [DW-1:0] sd;
      sd = (r == 2 || r == 5) ? '0 : DW'($urandom);
      cyc(1'b1, 1'b1, sd);                      // R2 load, R10 init over en
      chk(cnt == 0 && hold == 0, "R10 init clears", cnt, 0);
      bursts = 0;
      for (int c = 0; c < 2000 && m_run; c++) begin
        if (r == 4 && c == 30) begin
          cyc(1'b1, 1'b1, DW'($urandom));        // R10 restart mid-burst
          chk(cnt == 0, "R10 mid-run restart", cnt, 0);
        end else if (c % 17 == 5) begin
          hsnap = hold;
          for (int k = 0; k < 4; k++) begin
            cyc(1'b0, 1'b0, DW'($urandom));
            chk(hold == hsnap && vld == 0, "R9 enable low holds", hold, hsnap);
          end
        end else begin
          cyc(1'b0, ($urandom % 4) != 0, DW'($urandom));
        end
        if (m_done) bursts++;
      end
      chk(bursts == 1, "R8 one done per run", bursts, 1);
      hsnap = hold;
      for (int k = 0; k < 6; k++) cyc(1'b0, 1'b1, DW'($urandom));
      chk(hold == hsnap && int'(cnt) == BURST, "R8 ignored after done", cnt, BURST);
      if (sd == '0) chk(int'(cnt) == BURST, "R2 zero seed fallback run", cnt, BURST);
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule